// File: doc/BRIEF.md
# Reset Sequence Controller

This block generates the internal reset of a small 8-bit microcontroller. Two sources can start it: an active-low reset pad shared with the board, and a one-cycle underflow pulse from the watchdog. The pad is open-drain. The block reads the pad level through `pad_in` and pulls it low through `pad_pd_en`. A pad low level is captured asynchronously, brought through a two-flop synchroniser and counted, so a glitch shorter than `FILT_LEN` clock edges has no effect. A watchdog underflow is stretched so that the pad is pulled low for `WDG_PULSE` cycles.

The sequence is a five-state machine. The states are PH_ACTIVE, PH_DELAY, PH_FETCH_LO, PH_FETCH_HI and PH_RUN, and the transitions are:
- PH_ACTIVE to PH_DELAY once the stretch is over, the settle window has passed and the pad is not filtered low.
- PH_DELAY to PH_FETCH_LO after `DLY_SHORT` or `DLY_LONG` cycles. The static option bit `opt_long_dly` picks which one, and the pad is held low for the whole of PH_DELAY.
- PH_FETCH_LO to PH_FETCH_HI, and PH_FETCH_HI to PH_RUN. These two cycles strobe the reset-vector addresses, the top of memory minus one and then the top of memory.
- PH_RUN to PH_ACTIVE on any reset request.
- PH_DELAY, PH_FETCH_LO and PH_FETCH_HI also go back to PH_ACTIVE on any reset request.
- The block's own power-on input `por_n` forces PH_ACTIVE.

The pad reads low while the block itself pulls it low. For this reason the pad is ignored while the block drives it and for a settle window of four cycles afterwards.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `por_n` is low, `rst_int`=1, `pad_pd_en`=0, `vec_rd`=0 and `vec_addr`=0. After release, PH_DELAY starts on the first rising edge and `rst_int` falls on edge DLY+3, where DLY is the selected delay.
- R2: PH_DELAY lasts exactly `DLY_SHORT` cycles when `opt_long_dly`=0 and exactly `DLY_LONG` cycles when it is 1, and `pad_pd_en`=1 in every one of those cycles.
- R3: The fetch is two cycles with `vec_rd`=1. The first has `vec_addr` equal to all ones with bit 0 cleared (FFFEh at the default width), the second has all ones (FFFFh). `rst_int` falls on the edge after the second.
- R4: A `wdg_uflow` sampled high at an edge sets `pad_pd_en` from that edge for exactly `WDG_PULSE` cycles. A new pulse reloads the count.
- R5: A pad low level that covers fewer than `FILT_LEN` rising edges is ignored: `rst_int` and `pad_pd_en` stay low.
- R6: A pad low level covering L ≥ `FILT_LEN` edges raises `rst_int` on edge `FILT_LEN`+4, counted from the first edge covered. PH_DELAY then begins on edge L+5, and `rst_int` falls on edge L+7+DLY.
- R7: After `pad_pd_en` falls, the pad is not read for a 4-cycle settle window. After a watchdog pulse sampled on edge 1, PH_DELAY begins on edge `WDG_PULSE`+6 and `rst_int` falls on edge `WDG_PULSE`+8+DLY.
- R8: A watchdog pulse in any phase returns the machine to PH_ACTIVE with `rst_int` held high, and all later timing restarts from that pulse.
- R9: The low level the block itself puts on the pad never starts a new sequence: `rst_int` stays low after the sequence ends.
- R10: `vec_rd` is high only in the two fetch cycles, and `vec_addr` is zero whenever `vec_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| por_n | input | 1 | Power-on reset of the block, active low, asynchronous |
| pad_in | input | 1 | Level read back from the open-drain reset pad, low = reset |
| pad_pd_en | output | 1 | Pull-down enable for the reset pad |
| wdg_uflow | input | 1 | Watchdog underflow, one-cycle pulse |
| opt_long_dly | input | 1 | Delay select: 0 = short, 1 = long; static |
| rst_int | output | 1 | Internal reset, active high |
| vec_rd | output | 1 | Reset-vector fetch strobe |
| vec_addr | output | ADDR_W | Reset-vector fetch address |

## Verification
The assertions assume that `wdg_uflow` is a clean synchronous pulse and that `opt_long_dly` does not change during PH_DELAY. They also assume that `pad_in` reads low whenever `pad_pd_en` is high, as an open-drain pad would. The bench models the pad as the wired-AND of its external driver and `pad_pd_en`. It changes the option bit only in PH_RUN or under `por_n`, and it drives every input at the falling clock edge, so each level covers a whole number of rising edges.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [2:0] {
        PH_ACTIVE   = 3'd0,
        PH_DELAY    = 3'd1,
        PH_FETCH_LO = 3'd2,
        PH_FETCH_HI = 3'd3,
        PH_RUN      = 3'd4
    } phase_t;
endpackage

// File: rtl/rstseq_pad_filter.sv
module rstseq_pad_filter #(
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pad_in,
    input  logic drive_en,
    output logic ext_req,
    output logic pad_quiet
);
    // the capture flop adds one sample to any low level, so the threshold is one higher
    localparam int HIT        = FILT_LEN + 1;
    localparam int CW         = $clog2(HIT + 1);
    localparam int SETTLE_LEN = SYNC_STAGES + 2;

    logic                  cap_q;
    logic                  sync_q [SYNC_STAGES];
    logic                  seen;
    logic [CW-1:0]         cnt_q;
    logic                  pad_low;
    logic [SETTLE_LEN-1:0] hist_q;
    logic                  mask;

    // holds a low level seen on the pad even with the clock stopped
    always_ff @(posedge clk or negedge por_n or negedge pad_in) begin
        if (!por_n)       cap_q <= 1'b0;
        else if (!pad_in) cap_q <= 1'b1;
        else              cap_q <= 1'b0;
    end

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) sync_q[s] <= 1'b0;
                else        sync_q[s] <= cap_q;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) sync_q[s] <= 1'b0;
                else        sync_q[s] <= sync_q[s-1];
            end
        end
    end

    assign seen = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                   cnt_q <= '0;
        else if (!seen)               cnt_q <= '0;
        else if (cnt_q != CW'(HIT))   cnt_q <= cnt_q + 1'b1;
    end

    assign pad_low = (cnt_q == CW'(HIT));

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) hist_q <= '0;
        else        hist_q <= {hist_q[SETTLE_LEN-2:0], drive_en};
    end

    assign mask      = drive_en | (|hist_q);
    assign ext_req   = pad_low & ~mask;
    assign pad_quiet = ~pad_low & ~mask;

    assert_low_needs_sample_R5: assert property (@(posedge clk) disable iff (!por_n)
        pad_low |-> $past(seen));

    assert_settle_window_R7: assert property (@(posedge clk) disable iff (!por_n)
        $fell(drive_en) |=> !pad_quiet && !ext_req);
endmodule

// File: rtl/rstseq_wdg_stretch.sv
module rstseq_wdg_stretch #(
    parameter int PULSE_LEN = 32
) (
    input  logic clk,
    input  logic por_n,
    input  logic trig,
    output logic busy
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)           cnt_q <= '0;
        else if (trig)        cnt_q <= CW'(PULSE_LEN);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    assert_stretch_load_R4: assert property (@(posedge clk) disable iff (!por_n)
        trig |=> cnt_q == CW'(PULSE_LEN));

    assert_stretch_step_R4: assert property (@(posedge clk) disable iff (!por_n)
        (busy && !trig) |=> cnt_q == CW'($past(cnt_q) - 1'b1));
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int DLY_SHORT = 256,
    parameter int DLY_LONG  = 4096,
    parameter int ADDR_W    = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wdg_uflow,
    input  logic              ext_req,
    input  logic              settle_ok,
    input  logic              opt_long,
    output logic              rst_int,
    output logic              delay_drive,
    output logic              vec_rd,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam int DW = $clog2(DLY_LONG + 1);
    localparam logic [ADDR_W-1:0] VEC_HI = '1;
    localparam logic [ADDR_W-1:0] VEC_LO = {{(ADDR_W-1){1'b1}}, 1'b0};

    phase_t        state_q, state_d;
    logic [DW-1:0] dcnt_q;
    logic [DW-1:0] dly_last;
    logic          req;

    assign dly_last = opt_long ? DW'(DLY_LONG - 1) : DW'(DLY_SHORT - 1);
    assign req      = wdg_uflow | ext_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_ACTIVE:   if (!wdg_uflow && settle_ok) state_d = PH_DELAY;
            PH_DELAY:    if (req)                     state_d = PH_ACTIVE;
                         else if (dcnt_q == dly_last) state_d = PH_FETCH_LO;
            PH_FETCH_LO: state_d = req ? PH_ACTIVE : PH_FETCH_HI;
            PH_FETCH_HI: state_d = req ? PH_ACTIVE : PH_RUN;
            PH_RUN:      if (req)                     state_d = PH_ACTIVE;
            default:     state_d = PH_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= PH_ACTIVE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                  dcnt_q <= '0;
        else if (state_q != PH_DELAY) dcnt_q <= '0;
        else                         dcnt_q <= dcnt_q + 1'b1;
    end

    always_comb begin
        rst_int     = 1'b1;
        delay_drive = 1'b0;
        vec_rd      = 1'b0;
        vec_addr    = '0;
        unique case (state_q)
            PH_ACTIVE:   ;
            PH_DELAY:    delay_drive = 1'b1;
            PH_FETCH_LO: begin vec_rd = 1'b1; vec_addr = VEC_LO; end
            PH_FETCH_HI: begin vec_rd = 1'b1; vec_addr = VEC_HI; end
            PH_RUN:      rst_int = 1'b0;
            default:     ;
        endcase
    end

    assert_delay_bound_R2: assert property (@(posedge clk) disable iff (!por_n)
        state_q == PH_DELAY |-> dcnt_q <= dly_last);

    assert_fetch_order_R3: assert property (@(posedge clk) disable iff (!por_n)
        state_q == PH_FETCH_LO |=> (state_q == PH_FETCH_HI || state_q == PH_ACTIVE));

    assert_release_after_fetch_R3: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_int) |-> $past(state_q) == PH_FETCH_HI);

    assert_fetch_in_reset_R10: assert property (@(posedge clk) disable iff (!por_n)
        vec_rd |-> rst_int);

    assert_wdg_restart_R8: assert property (@(posedge clk) disable iff (!por_n)
        wdg_uflow |=> state_q == PH_ACTIVE);
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl #(
    parameter int FILT_LEN  = 4,
    parameter int WDG_PULSE = 32,
    parameter int DLY_SHORT = 256,
    parameter int DLY_LONG  = 4096,
    parameter int ADDR_W    = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              pad_in,
    output logic              pad_pd_en,
    input  logic              wdg_uflow,
    input  logic              opt_long_dly,
    output logic              rst_int,
    output logic              vec_rd,
    output logic [ADDR_W-1:0] vec_addr
);
    logic ext_req;
    logic pad_quiet;
    logic wdg_busy;
    logic delay_drive;
    logic settle_ok;

    rstseq_pad_filter #(
        .FILT_LEN   (FILT_LEN),
        .SYNC_STAGES(2)
    ) u_filter (
        .clk      (clk),
        .por_n    (por_n),
        .pad_in   (pad_in),
        .drive_en (pad_pd_en),
        .ext_req  (ext_req),
        .pad_quiet(pad_quiet)
    );

    rstseq_wdg_stretch #(
        .PULSE_LEN(WDG_PULSE)
    ) u_stretch (
        .clk  (clk),
        .por_n(por_n),
        .trig (wdg_uflow),
        .busy (wdg_busy)
    );

    assign settle_ok = pad_quiet & ~wdg_busy;

    rstseq_fsm #(
        .DLY_SHORT(DLY_SHORT),
        .DLY_LONG (DLY_LONG),
        .ADDR_W   (ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .wdg_uflow  (wdg_uflow),
        .ext_req    (ext_req),
        .settle_ok  (settle_ok),
        .opt_long   (opt_long_dly),
        .rst_int    (rst_int),
        .delay_drive(delay_drive),
        .vec_rd     (vec_rd),
        .vec_addr   (vec_addr)
    );

    assign pad_pd_en = wdg_busy | delay_drive;

    assert_pull_keeps_reset_R7: assert property (@(posedge clk) disable iff (!por_n)
        pad_pd_en |-> rst_int);
endmodule

// File: tb/rstseq_ctrl_test.sv
module rstseq_ctrl_test;
    localparam int F  = 3;
    localparam int W  = 8;
    localparam int NS = 16;
    localparam int NL = 40;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        ext_low = 1'b0;
    logic        wdg_uflow = 1'b0;
    logic        opt_long_dly = 1'b0;
    logic        pad_in;
    logic        pad_pd_en;
    logic        rst_int;
    logic        vec_rd;
    logic [15:0] vec_addr;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign pad_in = ~(ext_low | pad_pd_en);

    rstseq_ctrl #(
        .FILT_LEN(F), .WDG_PULSE(W), .DLY_SHORT(NS), .DLY_LONG(NL), .ADDR_W(16)
    ) uut (
        .clk(clk), .por_n(por_n), .pad_in(pad_in), .pad_pd_en(pad_pd_en),
        .wdg_uflow(wdg_uflow), .opt_long_dly(opt_long_dly),
        .rst_int(rst_int), .vec_rd(vec_rd), .vec_addr(vec_addr)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // index 0 is the current falling edge; outputs sampled before inputs are driven
    task automatic run_case(input int ext_len, input int p1, input int p2, input bit rel_por,
                            input int maxc, output int rise_i, output int fall_i,
                            output int pd_first, output int pd_cnt, output int fetch_ok,
                            output int relapse, output int idle_ok);
        logic       r1, r2;
        logic [15:0] a1, a2;
        r1 = 0; r2 = 0; a1 = 0; a2 = 0;
        rise_i = -1; fall_i = -1; pd_first = -1; pd_cnt = 0;
        fetch_ok = 0; relapse = 0; idle_ok = 1;
        for (int i = 0; i <= maxc; i++) begin
            @(negedge clk);
            if (rst_int && rise_i < 0) rise_i = i;
            if (!rst_int && rise_i >= 0 && fall_i < 0) begin
                fall_i = i;
                fetch_ok = (r2 && a2 == 16'hFFFE && r1 && a1 == 16'hFFFF) ? 1 : 0;
            end
            if (rst_int && fall_i >= 0) relapse = 1;
            if (pad_pd_en) begin
                pd_cnt++;
                if (pd_first < 0) pd_first = i;
            end
            if (!vec_rd && vec_addr != 16'h0) idle_ok = 0;
            r2 = r1; a2 = a1; r1 = vec_rd; a1 = vec_addr;
            ext_low   = (i < ext_len);
            wdg_uflow = (i == p1 || i == p2);
            if (rel_por && i == 0) por_n = 1'b1;
        end
        ext_low = 1'b0;
        wdg_uflow = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int rise, fall, pdf, pdc, fok, rel, idl, dly;
        // R1 reset state
        repeat (4) @(negedge clk);
        chk("R1", "rst_int in reset", int'(rst_int), 1);
        chk("R1", "pad_pd_en in reset", int'(pad_pd_en), 0);
        chk("R1", "vec_rd in reset", int'(vec_rd), 0);
        chk("R1", "vec_addr in reset", int'(vec_addr), 0);

        for (int opt = 0; opt < 2; opt++) begin
            dly = opt ? NL : NS;
            @(negedge clk);
            por_n = 1'b0;
            opt_long_dly = opt[0];
            repeat (3) @(negedge clk);
            run_case(0, -1, -1, 1, dly + 30, rise, fall, pdf, pdc, fok, rel, idl);
            chk("R1", "release edge after por", fall, dly + 3);
            chk("R2", "delay start after por", pdf, 1);
            chk("R2", "delay length after por", pdc, dly);
            chk("R3", "fetch addresses after por", fok, 1);
            chk("R9", "no relapse after por", rel, 0);
            chk("R10", "idle address after por", idl, 1);

            // single watchdog underflow
            run_case(0, 0, -1, 0, W + dly + 30, rise, fall, pdf, pdc, fok, rel, idl);
            chk("R8", "reset rise on watchdog", rise, 1);
            chk("R4", "pull-down start on watchdog", pdf, 1);
            chk("R4", "stretch plus delay drive", pdc, W + dly);
            chk("R7", "release edge after watchdog", fall, W + 8 + dly);
            chk("R3", "fetch addresses after watchdog", fok, 1);
            chk("R9", "no relapse after watchdog", rel, 0);
            chk("R10", "idle address after watchdog", idl, 1);

            // external pad pulses around the filter length
            for (int len = 1; len <= F + 3; len++) begin
                run_case(len, -1, -1, 0, len + dly + 30, rise, fall, pdf, pdc, fok, rel, idl);
                if (len < F) begin
                    chk("R5", "short glitch ignored (rise)", rise, -1);
                    chk("R5", "short glitch ignored (pull)", pdc, 0);
                end else begin
                    chk("R6", "reset rise on pad", rise, F + 4);
                    chk("R6", "release edge after pad", fall, len + 7 + dly);
                    chk("R2", "delay start after pad", pdf, len + 5);
                    chk("R2", "delay length after pad", pdc, dly);
                    chk("R3", "fetch addresses after pad", fok, 1);
                    chk("R9", "no relapse after pad", rel, 0);
                end
            end

            // second underflow at every offset of the running sequence
            for (int k = 1; k <= W + dly + 9; k++) begin
                run_case(0, 0, k, 0, k + W + dly + 30, rise, fall, pdf, pdc, fok, rel, idl);
                if (k < W + 8 + dly)
                    chk("R8", "restart by second watchdog", fall, k + W + 8 + dly);
                else
                    chk("R8", "second watchdog after release", fall, W + 8 + dly);
                chk("R3", "fetch addresses before release", fok, 1);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule